// File: doc/BRIEF.md
# Shared-Bus Flash Die Operation Scheduler

This block takes read, program, erase and copy-back commands aimed at a group of flash dies that share one 8-bit page transfer bus, and runs as many of them at once as the hardware rules permit. Each command names a die, a plane and an operation, and carries a tag. The block holds one operation for each die and plane pair, with a private cycle timer. It raises a start strobe when the operation's array phase begins, grants the shared bus to one page transfer at a time, and hands back each finished operation with its tag.

Array work on any number of dies may overlap, and it may overlap with the single transfer that owns the bus. A read senses the page first and then moves it across the bus. A program moves the data across the bus first and then writes the cells. Erase and copy-back never touch the bus, so a long erase on one die does not hold up traffic to the others. A second command for a plane pair that is already busy waits at the input until that pair is free.

Top module: `flash_sched`

## Requirements
- R1: After reset every die and plane pair is idle: cmd_ready is high, and comp_valid, bus_gnt, bus_busy and every arr_go bit are low.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is high only when the slot for (cmd_die, cmd_plane >> 1) holds no operation, so a command to a busy plane pair waits while the other pairs of the same die still accept.
- R3: A read (cmd_op 0) runs its array phase for T_READ cycles, then waits for the bus and transfers for T_XFER cycles; with the bus free it completes T_READ + T_XFER + 1 cycles after the accepting edge, and its arr_go bit is high in the first cycle after that edge.
- R4: A program (cmd_op 1) transfers first and then runs its array phase for T_PROG cycles; with the bus free it completes T_XFER + T_PROG + 1 cycles after the accepting edge, and arr_go bit die*(NPLANE/2)+plane/2 is high in the first array cycle, T_XFER + 1 cycles after that edge.
- R5: An erase (cmd_op 2) and a copy-back (cmd_op 3) never receive a bus grant and complete T_ERASE and T_COPY cycles after the accepting edge.
- R6: At most one transfer holds the bus; bus_busy is high through each transfer, and two grants are at least T_XFER + 1 cycles apart.
- R7: An erase in progress on one die does not delay reads on other dies or on another plane pair of the same die.
- R8: When the bus frees, it is granted to the waiting slot found first when searching upward from the slot after the last one granted, wrapping around.
- R9: At most one completion is reported per cycle, in the order the operations finished; operations that finished in the same cycle are reported by ascending slot number die*(NPLANE/2)+plane/2.
- R10: Each completion carries the die, operation code and tag given with its command, and every accepted command completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Target plane pair free, command taken this edge if valid |
| cmd_die | input | $clog2(NDIE) | Target die |
| cmd_plane | input | $clog2(NPLANE) | Target plane; plane >> 1 selects the pair |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 copy-back |
| cmd_tag | input | TAGW | Caller tag returned on completion |
| arr_go | output | NDIE*NPLANE/2 | One-cycle array start strobe per die and plane pair |
| bus_gnt | output | 1 | Shared bus granted to a transfer this cycle |
| bus_gnt_die | output | $clog2(NDIE) | Die that receives the grant |
| bus_gnt_wr | output | 1 | High when the granted transfer carries program data to the die |
| bus_busy | output | 1 | A transfer holds the bus |
| comp_valid | output | 1 | A completion is reported this cycle |
| comp_die | output | $clog2(NDIE) | Die of the completed operation |
| comp_op | output | 2 | Operation code of the completed operation |
| comp_tag | output | TAGW | Tag of the completed operation |

## Verification
The bench builds the block with four dies of four planes and shrinks the timings to 3 cycles for a read, 6 for a transfer, 12 for a program, 40 for an erase and 8 for a copy-back. With these values several transfers queue behind one another within a few cycles, so the round-robin search order can be told apart from arrival order, and an erase lasts long enough for reads on other dies to finish first. The short timings also let a program, a read and a copy-back be placed so that three finish on the same edge and a fourth one cycle later, which exposes the ordering of completions and the tie rule.

// File: rtl/flash_sched.sv
module flash_sched #(
  parameter int NDIE    = 4,
  parameter int NPLANE  = 4,
  parameter int TAGW    = 8,
  parameter int T_READ  = 25,
  parameter int T_XFER  = 100,
  parameter int T_PROG  = 200,
  parameter int T_ERASE = 1500,
  parameter int T_COPY  = 225,
  localparam int DW    = $clog2(NDIE),
  localparam int PW    = $clog2(NPLANE),
  localparam int NPAIR = NPLANE / 2,
  localparam int NSLOT = NDIE * NPAIR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [DW-1:0]    cmd_die,
  input  logic [PW-1:0]    cmd_plane,
  input  logic [1:0]       cmd_op,
  input  logic [TAGW-1:0]  cmd_tag,
  output logic [NSLOT-1:0] arr_go,
  output logic             bus_gnt,
  output logic [DW-1:0]    bus_gnt_die,
  output logic             bus_gnt_wr,
  output logic             bus_busy,
  output logic             comp_valid,
  output logic [DW-1:0]    comp_die,
  output logic [1:0]       comp_op,
  output logic [TAGW-1:0]  comp_tag
);
  localparam int SW   = $clog2(NSLOT);
  localparam int PRW  = $clog2(NPAIR);
  localparam int AW   = SW + 1;
  localparam int TM1  = (T_READ > T_XFER) ? T_READ : T_XFER;
  localparam int TM2  = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_COPY) ? TM3 : T_COPY;
  localparam int CW   = $clog2(TMAX);

  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_ER = 2'd2, OP_CB = 2'd3;
  localparam logic [2:0] S_IDLE = 3'd0, S_ARR = 3'd1, S_WAIT = 3'd2, S_XFER = 3'd3, S_DONE = 3'd4;

  logic [2:0]      st  [NSLOT];
  logic [CW-1:0]   cnt [NSLOT];
  logic [1:0]      op  [NSLOT];
  logic [TAGW-1:0] tag [NSLOT];
  logic [AW-1:0]   age [NSLOT];
  logic [SW-1:0]   rr_ptr;

  logic [NSLOT-1:0] xfer_vec, wait_vec, idle_vec;
  logic [SW-1:0]    tgt, gnt_slot, comp_slot;
  logic             gnt_any, comp_any, acc;
  logic [AW-1:0]    best_age;

  assign tgt       = SW'(int'(cmd_die) * NPAIR + int'(cmd_plane >> 1));
  assign cmd_ready = idle_vec[tgt];
  assign acc       = cmd_valid & cmd_ready;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      xfer_vec[s] = (st[s] == S_XFER);
      wait_vec[s] = (st[s] == S_WAIT);
      idle_vec[s] = (st[s] == S_IDLE);
    end
  end

  assign bus_busy = |xfer_vec;

  always_comb begin
    gnt_any  = 1'b0;
    gnt_slot = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (!gnt_any && wait_vec[rr_ptr + SW'(k)]) begin
        gnt_any  = 1'b1;
        gnt_slot = rr_ptr + SW'(k);
      end
    end
  end

  assign bus_gnt     = gnt_any & ~bus_busy;
  assign bus_gnt_die = gnt_slot[SW-1:PRW];
  assign bus_gnt_wr  = bus_gnt & (op[gnt_slot] == OP_PG);

  always_comb begin
    comp_any  = 1'b0;
    comp_slot = '0;
    best_age  = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (st[s] == S_DONE && (!comp_any || age[s] > best_age)) begin
        comp_any  = 1'b1;
        comp_slot = SW'(s);
        best_age  = age[s];
      end
    end
  end

  assign comp_valid = comp_any;
  assign comp_die   = comp_slot[SW-1:PRW];
  assign comp_op    = op[comp_slot];
  assign comp_tag   = tag[comp_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
      arr_go <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        st[s]  <= S_IDLE;
        cnt[s] <= '0;
        op[s]  <= OP_RD;
        tag[s] <= '0;
        age[s] <= '0;
      end
    end else begin
      if (bus_gnt) rr_ptr <= gnt_slot + SW'(1);
      for (int s = 0; s < NSLOT; s++) begin
        arr_go[s] <= 1'b0;
        case (st[s])
          S_IDLE: if (acc && tgt == SW'(s)) begin
            op[s]  <= cmd_op;
            tag[s] <= cmd_tag;
            age[s] <= '0;
            case (cmd_op)
              OP_RD: begin st[s] <= S_ARR; cnt[s] <= CW'(T_READ - 1);  arr_go[s] <= 1'b1; end
              OP_PG: st[s] <= S_WAIT;
              OP_ER: begin st[s] <= S_ARR; cnt[s] <= CW'(T_ERASE - 1); arr_go[s] <= 1'b1; end
              default: begin st[s] <= S_ARR; cnt[s] <= CW'(T_COPY - 1); arr_go[s] <= 1'b1; end
            endcase
          end
          S_ARR: begin
            if (cnt[s] == '0) st[s] <= (op[s] == OP_RD) ? S_WAIT : S_DONE;
            else cnt[s] <= cnt[s] - CW'(1);
          end
          S_WAIT: if (bus_gnt && gnt_slot == SW'(s)) begin
            st[s]  <= S_XFER;
            cnt[s] <= CW'(T_XFER - 1);
          end
          S_XFER: begin
            if (cnt[s] != '0) cnt[s] <= cnt[s] - CW'(1);
            else if (op[s] == OP_RD) st[s] <= S_DONE;
            else begin
              st[s]     <= S_ARR;
              cnt[s]    <= CW'(T_PROG - 1);
              arr_go[s] <= 1'b1;
            end
          end
          S_DONE: begin
            if (comp_slot == SW'(s)) st[s] <= S_IDLE;
            else age[s] <= age[s] + AW'(1);
          end
          default: st[s] <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_sched_chk.sv
module flash_sched_chk #(
  parameter int NSLOT = 8,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_gnt,
  input logic             bus_busy,
  input logic [NSLOT-1:0] xfer_vec,
  input logic [NSLOT-1:0] idle_vec,
  input logic [1:0]       gnt_op,
  input logic             comp_valid,
  input logic [SW-1:0]    comp_slot
);
  assert_single_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_vec));

  assert_gnt_then_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |=> bus_busy);

  assert_no_bus_for_bulk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> !gnt_op[1]);

  assert_reported_slot_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    comp_valid |=> idle_vec[$past(comp_slot)]);
endmodule

bind flash_sched flash_sched_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_gnt    (bus_gnt),
  .bus_busy   (bus_busy),
  .xfer_vec   (xfer_vec),
  .idle_vec   (idle_vec),
  .gnt_op     (op[gnt_slot]),
  .comp_valid (comp_valid),
  .comp_slot  (comp_slot)
);

// File: tb/sim_flash_sched.sv
module sim_flash_sched;
  localparam int NDIE = 4, NPLANE = 4, TAGW = 8;
  localparam int TR = 3, TX = 6, TP = 12, TE = 40, TC = 8;
  localparam int NSLOT = NDIE * NPLANE / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_die = '0;
  logic [1:0] cmd_plane = '0;
  logic [1:0] cmd_op = '0;
  logic [TAGW-1:0] cmd_tag = '0;
  logic [NSLOT-1:0] arr_go;
  logic bus_gnt, bus_gnt_wr, bus_busy, comp_valid;
  logic [1:0] bus_gnt_die, comp_die, comp_op;
  logic [TAGW-1:0] comp_tag;

  flash_sched #(.NDIE(NDIE), .NPLANE(NPLANE), .TAGW(TAGW), .T_READ(TR), .T_XFER(TX),
                .T_PROG(TP), .T_ERASE(TE), .T_COPY(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_die(cmd_die), .cmd_plane(cmd_plane), .cmd_op(cmd_op), .cmd_tag(cmd_tag),
    .arr_go(arr_go), .bus_gnt(bus_gnt), .bus_gnt_die(bus_gnt_die), .bus_gnt_wr(bus_gnt_wr),
    .bus_busy(bus_busy), .comp_valid(comp_valid), .comp_die(comp_die), .comp_op(comp_op),
    .comp_tag(comp_tag));

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, pending = 0, next_tag = 0;
  int acc_cyc [256], comp_cyc [256], seen [256], exp_die [256], exp_op [256];
  int glog [512], gcnt = 0, clog [512], ccnt = 0, last_gnt = -1000;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lat(input int op);
    case (op)
      0: return TR + TX + 1;
      1: return TX + TP + 1;
      2: return TE;
      default: return TC;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_gnt) begin
        chk(cyc - last_gnt > TX, "R6 grant spacing", cyc - last_gnt, TX + 1);
        last_gnt = cyc;
        if (gcnt < 512) glog[gcnt] = int'(bus_gnt_die);
        gcnt++;
      end
      if (comp_valid) begin
        int t;
        t = int'(comp_tag);
        chk(seen[t] == 0 && exp_die[t] == int'(comp_die) && exp_op[t] == int'(comp_op),
            "R10 completion fields", int'(comp_die) * 4 + int'(comp_op), exp_die[t] * 4 + exp_op[t]);
        seen[t]++;
        comp_cyc[t] = cyc;
        chk(cyc - acc_cyc[t] >= lat(exp_op[t]), "R9 completion not early", cyc - acc_cyc[t], lat(exp_op[t]));
        if (ccnt < 512) clog[ccnt] = t;
        ccnt++;
        pending--;
      end
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic issue(input int die, input int plane, input int op, output int tg);
    tg = next_tag++;
    cmd_die = 2'(die); cmd_plane = 2'(plane); cmd_op = 2'(op); cmd_tag = TAGW'(tg);
    exp_die[tg] = die; exp_op[tg] = op; seen[tg] = 0;
    cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    pending++;
    @(negedge clk);
    acc_cyc[tg] = cyc;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (pending > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000 && !done) @(negedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int tg, k, e, r1, r2, r3, c0, a, b, c, d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_ready && !comp_valid && !bus_gnt && !bus_busy && arr_go == '0, "R1 reset state", int'(cmd_ready), 1);

    for (int o = 0; o < 4; o++) begin
      issue(0, 0, o, tg);
      if (o == 0) chk(arr_go[0], "R3 read array strobe", int'(arr_go[0]), 1);
      if (o == 1) begin
        wait_cyc(acc_cyc[tg] + TX + 1);
        chk(arr_go[0], "R4 program array strobe", int'(arr_go[0]), 1);
      end
      c0 = gcnt;
      drain();
      chk(comp_cyc[tg] - acc_cyc[tg] == lat(o), o < 2 ? "R3 R4 latency" : "R5 latency",
          comp_cyc[tg] - acc_cyc[tg], lat(o));
      if (o >= 2) chk(gcnt == c0, "R5 no bus grant", gcnt - c0, 0);
    end

    issue(1, 0, 2, e);
    cmd_die = 2'd1; cmd_plane = 2'd1; #1;
    chk(!cmd_ready, "R2 same pair blocked", int'(cmd_ready), 0);
    cmd_plane = 2'd2; #1;
    chk(cmd_ready, "R2 other pair free", int'(cmd_ready), 1);
    @(negedge clk);
    issue(2, 0, 0, r1);
    issue(1, 3, 0, r2);
    issue(1, 1, 0, r3);
    drain();
    chk(comp_cyc[r1] - acc_cyc[r1] == lat(0), "R7 read beside erase latency", comp_cyc[r1] - acc_cyc[r1], lat(0));
    chk(comp_cyc[r1] < comp_cyc[e], "R7 other die before erase", comp_cyc[r1], comp_cyc[e]);
    chk(comp_cyc[r2] < comp_cyc[e], "R7 other pair before erase", comp_cyc[r2], comp_cyc[e]);
    chk(acc_cyc[r3] > comp_cyc[e], "R2 waits for pair", acc_cyc[r3], comp_cyc[e] + 1);

    c0 = gcnt;
    issue(3, 0, 1, tg);
    issue(2, 0, 1, tg);
    issue(1, 0, 1, tg);
    drain();
    chk(gcnt - c0 == 3 && glog[c0] == 3, "R8 first grant", glog[c0], 3);
    chk(glog[c0 + 1] == 1, "R8 round robin second", glog[c0 + 1], 1);
    chk(glog[c0 + 2] == 2, "R8 round robin third", glog[c0 + 2], 2);

    c0 = ccnt;
    issue(0, 0, 1, a);
    k = acc_cyc[a];
    wait_cyc(k + 8);  issue(3, 0, 0, b);
    wait_cyc(k + 10); issue(1, 0, 3, c);
    issue(0, 2, 3, d);
    drain();
    chk(acc_cyc[b] == k + 9 && acc_cyc[d] == k + 12, "R9 setup", acc_cyc[d], k + 12);
    chk(clog[c0] == a && comp_cyc[a] == k + 19, "R9 order first", comp_cyc[a], k + 19);
    chk(clog[c0 + 1] == c && comp_cyc[c] == k + 20, "R9 tie lowest slot", clog[c0 + 1], c);
    chk(clog[c0 + 2] == b && comp_cyc[b] == k + 21, "R9 tie next slot", clog[c0 + 2], b);
    chk(clog[c0 + 3] == d && comp_cyc[d] == k + 22, "R9 older before newer", clog[c0 + 3], d);

    c0 = next_tag;
    for (int i = 0; i < 150; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), tg);
    end
    drain();
    for (int t = c0; t < next_tag; t++)
      chk(seen[t] == 1, "R10 completes once", seen[t], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule